// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block gives a processor register-level control over a bank of general-purpose pins, up to 32 of them. Software reaches it through a simple 32-bit APB-style register bus. Each pin has its own controls: a direction, an output enable and an output level. A select bit can also hand the pin to an alternate-function path, which then supplies direction, enable and level in place of the registers. Pin inputs are brought into the clock domain by a two-stage synchronizer, and software reads the synchronized levels.

Every pin can raise an interrupt on a high level, a low level, a rising edge, a falling edge or either edge. A detected condition latches a status bit whether or not the pin is masked. Mask bits cannot be written directly. One register clears mask bits for each 1 written, and another sets them. No acknowledge register exists: reading the status register returns the latched bits and clears all of them in the same access. A single interrupt output is raised whenever any latched status bit is unmasked.

The register bus has no wait states. An access completes in the cycle where `psel` and `penable` are both high. Read data is valid in that cycle, and writes and the status clear take effect at the clock edge that ends it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 bypass select, 0x04 direction, 0x08 output enable, 0x0C output level, 0x24 trigger type, 0x28 trigger polarity and 0x2C both-edge select. All of them read back what was written. Bits at and above NPINS read as zero and ignore writes.
- R2: After reset, direction (0x04) and mask (0x14) read all ones in the implemented bits. Every other register reads zero, and `irq` is 0.
- R3: `pad_oe[i]` is 1 only when the pin's effective direction bit is 0 (output) and its effective enable bit is 1. `pad_out[i]` follows the effective output level.
- R4: When bypass bit i is 1, `alt_dir[i]`, `alt_oe[i]` and `alt_out[i]` become the effective direction, enable and level. When the bit is 0, the registers at 0x04, 0x08 and 0x0C supply them.
- R5: Offset 0x10 returns `pin_in` after two synchronizer stages. A change in `pin_in` is readable from the third clock edge after it. Offset 0x0C returns the stored level, not the pad.
- R6: Writing to 0x18 clears each mask bit written as 1, and writing to 0x1C sets each mask bit written as 1. Zero bits in either write leave the mask unchanged. The mask reads at 0x14.
- R7: A trigger type bit of 1 selects level sensitivity. In level mode, a polarity bit of 1 detects a high level and 0 detects a low level.
- R8: A trigger type bit of 0 selects edge mode. A polarity bit of 1 detects rising edges and 0 detects falling edges. A both-edge bit of 1 detects either edge.
- R9: Reading 0x20 returns the latched status and clears every bit in that access. A condition that is true in the clearing cycle keeps its bit set, so a persisting level is still latched.
- R10: Status bits latch regardless of mask. `irq` is 1 exactly when some status bit is set and its mask bit is 0.
- R11: Writes to 0x10, 0x14 and 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NPINS | Asynchronous pad input levels |
| alt_dir | input | NPINS | Alternate-function direction (1 = input) |
| alt_oe | input | NPINS | Alternate-function output enable |
| alt_out | input | NPINS | Alternate-function output level |
| pad_out | output | NPINS | Pad output level |
| pad_oe | output | NPINS | Pad drive enable |
| irq | output | 1 | Combined interrupt to the processor |

## Verification
The bench builds the block with NPINS = 24. This leaves eight unimplemented bits in every register, so all-ones writes show that those bits stay zero and that only the 24 real pins respond. Random register values and random alternate-function inputs exercise the pad muxing with each pin in a different mix of bypass, direction and enable. Directed pin waveforms then drive one pin per detection mode, which makes the clear-on-read race with a persisting level observable.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned BUS_W = 32;

  // Word index of each register (byte offset / 4). Software depends on these.
  typedef enum logic [3:0] {
    WIX_BYPASS  = 4'd0,
    WIX_DIR     = 4'd1,
    WIX_OE      = 4'd2,
    WIX_OUT     = 4'd3,
    WIX_IN      = 4'd4,
    WIX_MASK    = 4'd5,
    WIX_UNMASK  = 4'd6,
    WIX_SETMASK = 4'd7,
    WIX_STATUS  = 4'd8,
    WIX_TRIG    = 4'd9,
    WIX_POL     = 4'd10,
    WIX_BOTH    = 4'd11
  } word_ix_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_lvl,
  output logic [NPINS-1:0] prev_lvl
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic meta_q, lvl_q, old_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        lvl_q  <= 1'b0;
        old_q  <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        lvl_q  <= meta_q;
        old_q  <= lvl_q;
      end
    end
    assign sync_lvl[i] = lvl_q;
    assign prev_lvl[i] = old_q;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] bypass,
  input  logic [NPINS-1:0] reg_dir,
  input  logic [NPINS-1:0] reg_oe,
  input  logic [NPINS-1:0] reg_out,
  input  logic [NPINS-1:0] alt_dir,
  input  logic [NPINS-1:0] alt_oe,
  input  logic [NPINS-1:0] alt_out,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic eff_dir, eff_oe, eff_out;
    always_comb begin
      if (bypass[i]) begin
        eff_dir = alt_dir[i];
        eff_oe  = alt_oe[i];
        eff_out = alt_out[i];
      end else begin
        eff_dir = reg_dir[i];
        eff_oe  = reg_oe[i];
        eff_out = reg_out[i];
      end
    end
    // direction 1 means input: enable is ignored then
    assign pad_oe[i]  = eff_oe & ~eff_dir;
    assign pad_out[i] = eff_out;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sync_lvl,
  input  logic [NPINS-1:0] prev_lvl,
  input  logic [NPINS-1:0] trig_lvl,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] mask,
  input  logic             stat_rd,
  output logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] status,
  output logic             irq
);
  logic [NPINS-1:0] rise, fall;
  assign rise = sync_lvl & ~prev_lvl;
  assign fall = ~sync_lvl & prev_lvl;

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    always_comb begin
      if (trig_lvl[i])  hit[i] = pol[i] ? sync_lvl[i] : ~sync_lvl[i];
      else if (both[i]) hit[i] = rise[i] | fall[i];
      else              hit[i] = pol[i] ? rise[i] : fall[i];
    end
  end

  logic [NPINS-1:0] status_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (stat_rd ? '0 : status_q) | hit;  // set wins
  end
  assign status = status_q;
  assign irq    = |(status_q & ~mask);
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [NPINS-1:0]  in_lvl,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  bypass,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  oe,
  output logic [NPINS-1:0]  outv,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  trig_lvl,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  both,
  output logic              stat_rd
);
  localparam int unsigned IX_W = ADDR_W - 2;

  logic            acc, wr;
  logic [IX_W-1:0] wix;
  logic [NPINS-1:0] wd;
  assign acc = psel & penable;
  assign wr  = acc & pwrite;
  assign wix = paddr[ADDR_W-1:2];
  assign wd  = pwdata[NPINS-1:0];
  assign stat_rd = acc & ~pwrite & (wix == IX_W'(WIX_STATUS));

  function automatic logic hit_ix(input logic [IX_W-1:0] a, input word_ix_e r);
    return a == IX_W'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass   <= '0;
      dir      <= '1;
      oe       <= '0;
      outv     <= '0;
      mask     <= '1;
      trig_lvl <= '0;
      pol      <= '0;
      both     <= '0;
    end else if (wr) begin
      if (hit_ix(wix, WIX_BYPASS))  bypass   <= wd;
      if (hit_ix(wix, WIX_DIR))     dir      <= wd;
      if (hit_ix(wix, WIX_OE))      oe       <= wd;
      if (hit_ix(wix, WIX_OUT))     outv     <= wd;
      if (hit_ix(wix, WIX_UNMASK))  mask     <= mask & ~wd;
      if (hit_ix(wix, WIX_SETMASK)) mask     <= mask | wd;
      if (hit_ix(wix, WIX_TRIG))    trig_lvl <= wd;
      if (hit_ix(wix, WIX_POL))     pol      <= wd;
      if (hit_ix(wix, WIX_BOTH))    both     <= wd;
    end
  end

  logic [NPINS-1:0] rsel;
  always_comb begin
    rsel = '0;
    if (acc && !pwrite) begin
      unique case (wix)
        IX_W'(WIX_BYPASS): rsel = bypass;
        IX_W'(WIX_DIR):    rsel = dir;
        IX_W'(WIX_OE):     rsel = oe;
        IX_W'(WIX_OUT):    rsel = outv;
        IX_W'(WIX_IN):     rsel = in_lvl;
        IX_W'(WIX_MASK):   rsel = mask;
        IX_W'(WIX_STATUS): rsel = status;
        IX_W'(WIX_TRIG):   rsel = trig_lvl;
        IX_W'(WIX_POL):    rsel = pol;
        IX_W'(WIX_BOTH):   rsel = both;
        default:           rsel = '0;
      endcase
    end
  end
  assign prdata = BUS_W'(rsel);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  alt_dir,
  input  logic [NPINS-1:0]  alt_oe,
  input  logic [NPINS-1:0]  alt_out,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic [NPINS-1:0] bypass_r, dir_r, oe_r, out_r, mask_r;
  logic [NPINS-1:0] trig_r, pol_r, both_r;
  logic [NPINS-1:0] sync_lvl, prev_lvl, hit_w, status_r;
  logic             stat_rd;

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .in_lvl(sync_lvl), .status(status_r),
    .bypass(bypass_r), .dir(dir_r), .oe(oe_r), .outv(out_r), .mask(mask_r),
    .trig_lvl(trig_r), .pol(pol_r), .both(both_r), .stat_rd(stat_rd)
  );

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .sync_lvl(sync_lvl), .prev_lvl(prev_lvl)
  );

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .bypass(bypass_r), .reg_dir(dir_r), .reg_oe(oe_r), .reg_out(out_r),
    .alt_dir(alt_dir), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_irq_unit #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .prev_lvl(prev_lvl),
    .trig_lvl(trig_r), .pol(pol_r), .both(both_r), .mask(mask_r),
    .stat_rd(stat_rd), .hit(hit_w), .status(status_r), .irq(irq)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq,
  input logic [NPINS-1:0]  bypass_r,
  input logic [NPINS-1:0]  dir_r,
  input logic [NPINS-1:0]  mask_r,
  input logic [NPINS-1:0]  status_r,
  input logic [NPINS-1:0]  hit_w
);
  logic wr_en, wr_dis, rd_st;
  assign wr_en  = psel & penable & pwrite  & (paddr[ADDR_W-1:2] == (ADDR_W-2)'(6));
  assign wr_dis = psel & penable & pwrite  & (paddr[ADDR_W-1:2] == (ADDR_W-2)'(7));
  assign rd_st  = psel & penable & ~pwrite & (paddr[ADDR_W-1:2] == (ADDR_W-2)'(8));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (prdata >> NPINS) == 32'd0);

  a_r3_no_drive_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~bypass_r & dir_r) == '0);

  a_r6_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_r & $past(pwdata[NPINS-1:0])) == '0);

  a_r6_mask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> (mask_r & $past(pwdata[NPINS-1:0])) == $past(pwdata[NPINS-1:0]));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |=> (status_r & ~$past(hit_w)) == '0);

  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_r != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_oe(pad_oe), .irq(irq),
  .bypass_r(bypass_r), .dir_r(dir_r), .mask_r(mask_r), .status_r(status_r),
  .hit_w(hit_w)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int unsigned NP = 24;
  localparam int unsigned AW = 8;
  localparam time CLK_PERIOD = 10;
  localparam logic [31:0] PM = (32'h1 << NP) - 32'h1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [NP-1:0] pin_in = '0, alt_dir = '0, alt_oe = '0, alt_out = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic irq;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .alt_dir(alt_dir), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] exp_oe(input logic [NP-1:0] b, d, o, ad, ao);
    return (b & ao & ~ad) | (~b & o & ~d);
  endfunction
  function automatic logic [NP-1:0] exp_out(input logic [NP-1:0] b, v, av);
    return (b & av) | (~b & v);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, w;
    logic [NP-1:0] b, d, o, v, m;
    void'($urandom(32'h5EED_0042));
    settle(3); rst_n = 1; settle(1);

    // R2 reset state
    bus_rd(8'h04, r); chk("R2 dir", r, PM);
    bus_rd(8'h14, r); chk("R2 mask", r, PM);
    bus_rd(8'h00, r); chk("R2 bypass", r, 0);
    bus_rd(8'h08, r); chk("R2 oe", r, 0);
    bus_rd(8'h0C, r); chk("R2 out", r, 0);
    bus_rd(8'h24, r); chk("R2 trig", r, 0);
    bus_rd(8'h2C, r); chk("R2 both", r, 0);
    bus_rd(8'h20, r); chk("R2 status", r, 0);
    chk("R2 irq", {31'd0, irq}, 0);

    // R1 readback with upper bits dropped
    bus_wr(8'h24, 32'hFFFF_FFFF); bus_rd(8'h24, r); chk("R1 trig ones", r, PM);
    for (int k = 0; k < 6; k++) begin
      w = $urandom(); bus_wr(8'h28, w); bus_rd(8'h28, r); chk("R1 pol", r, w & PM);
      w = $urandom(); bus_wr(8'h2C, w); bus_rd(8'h2C, r); chk("R1 both", r, w & PM);
    end
    bus_wr(8'h24, 0); bus_wr(8'h28, 0); bus_wr(8'h2C, 0);

    // R3/R4 pad muxing, R5 output readback
    for (int k = 0; k < 8; k++) begin
      b = NP'($urandom()); d = NP'($urandom()); o = NP'($urandom()); v = NP'($urandom());
      if (k == 0) b = '0;
      if (k == 1) b = '1;
      bus_wr(8'h00, 32'(b)); bus_wr(8'h04, 32'(d));
      bus_wr(8'h08, 32'(o)); bus_wr(8'h0C, 32'(v));
      alt_dir = NP'($urandom()); alt_oe = NP'($urandom()); alt_out = NP'($urandom());
      #1;
      chk("R3 R4 pad_oe", 32'(pad_oe), 32'(exp_oe(b, d, o, alt_dir, alt_oe)));
      chk("R3 R4 pad_out", 32'(pad_out), 32'(exp_out(b, v, alt_out)));
      bus_rd(8'h0C, r); chk("R5 out stored", r, 32'(v));
    end

    // R5 synchronized input
    for (int k = 0; k < 5; k++) begin
      pin_in = NP'($urandom());
      @(negedge clk); @(negedge clk);
      bus_rd(8'h10, r); chk("R5 input", r, 32'(pin_in));
    end

    // R6 mask set/clear with a bench model
    m = '1;
    for (int k = 0; k < 6; k++) begin
      w = $urandom();
      if (k[0]) begin bus_wr(8'h1C, w); m = m | w[NP-1:0]; end
      else      begin bus_wr(8'h18, w); m = m & ~w[NP-1:0]; end
      bus_rd(8'h14, r); chk("R6 mask", r, 32'(m));
    end
    bus_wr(8'h1C, 32'hFFFF_FFFF);

    // R11 read-only writes ignored
    bus_wr(8'h14, 32'h0); bus_rd(8'h14, r); chk("R11 mask wr", r, PM);
    bus_wr(8'h10, 32'h00AA_5555); bus_rd(8'h10, r); chk("R11 input wr", r, 32'(pin_in));

    // quiet pins and clear status
    pin_in = '0; settle(5);
    bus_rd(8'h20, r); bus_rd(8'h20, r); chk("R9 cleared", r, 0);
    bus_wr(8'h20, 32'hFFFF_FFFF); bus_rd(8'h20, r); chk("R11 status wr", r, 0);

    // config: pin0 level-high, pin1 rising, pin2 both, pin3 falling, pin4 level-low
    bus_wr(8'h24, 32'h11); bus_wr(8'h28, 32'h03); bus_wr(8'h2C, 32'h04);
    pin_in[4] = 1'b1; settle(5);
    bus_rd(8'h20, r); bus_rd(8'h20, r); chk("R7 quiet", r, 0);

    // R8 rising, R10 masked latch
    pin_in[1] = 1'b1; settle(5);
    chk("R10 masked irq", {31'd0, irq}, 0);
    bus_wr(8'h18, 32'h2); #1 chk("R10 unmasked irq", {31'd0, irq}, 1);
    bus_rd(8'h20, r); chk("R8 rising", r, 32'h2);
    #1 chk("R9 irq after clear", {31'd0, irq}, 0);
    pin_in[1] = 1'b0; settle(5);
    bus_rd(8'h20, r); chk("R8 rising ignores fall", r, 0);
    bus_wr(8'h1C, 32'h2);

    // R8 falling on pin3
    pin_in[3] = 1'b1; settle(5);
    bus_rd(8'h20, r); chk("R8 falling ignores rise", r, 0);
    pin_in[3] = 1'b0; settle(5);
    bus_rd(8'h20, r); chk("R8 falling", r, 32'h8);

    // R8 both edges on pin2
    pin_in[2] = 1'b1; settle(5);
    bus_rd(8'h20, r); chk("R8 both rise", r, 32'h4);
    pin_in[2] = 1'b0; settle(5);
    bus_rd(8'h20, r); chk("R8 both fall", r, 32'h4);

    // R7/R9 level-high persisting through clearing read
    pin_in[0] = 1'b1; settle(5);
    bus_rd(8'h20, r); chk("R7 level high", r, 32'h1);
    bus_rd(8'h20, r); chk("R9 set wins", r, 32'h1);
    pin_in[0] = 1'b0; settle(5);
    bus_rd(8'h20, r); chk("R9 last latch", r, 32'h1);
    bus_rd(8'h20, r); chk("R9 clear", r, 0);

    // R7 level-low on pin4
    pin_in[4] = 1'b0; settle(5);
    bus_wr(8'h18, 32'h10); #1 chk("R10 irq level", {31'd0, irq}, 1);
    bus_rd(8'h20, r); chk("R7 level low", r, 32'h10);
    pin_in[4] = 1'b1; settle(5);
    bus_rd(8'h20, r); chk("R7 low latched", r, 32'h10);
    bus_rd(8'h20, r); chk("R7 low gone", r, 0);
    #1 chk("R10 irq idle", {31'd0, irq}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule